// File: doc/BRIEF.md
# MSI Interrupt Message Generator

This block converts outbound interrupt events into message-signalled interrupt write requests for a bus master. Three interrupt sources feed it: a post-queue source, a doorbell source and a message source. A rising edge on any source sets a pending bit. While message generation is enabled, the block raises a request that carries the programmed target address, a 32-bit data word and byte enables. The request is held until the bus master accepts it with ready.

Software sets the block up through a small register port. The port holds a 16-bit message data value, a word-aligned message address, an enable bit and a 3-bit message-count field. With one message allocated, every source shares the programmed data value unchanged. With two messages allocated, bit 0 of the data tells the classes apart: 0 marks the post-queue source, and 1 marks the doorbell/message class.

Top module: `msi_msg_gen`

## Requirements
- R1: After reset, req_valid_o is 0 and all three registers read back as zero.
- R2: Register index 0 is control (bit 0 = enable, bits 6:4 = message-count field). Index 1 is the address, with bits 1:0 always 0. Index 2 is the message data, held in bits 15:0, with bits 31:16 reading 0. Index 3 reads 0. A write takes effect at the clock edge and is readable from that point on.
- R3: A source is recorded only on its rising edge. A source held high produces exactly one request.
- R4: When the message-count field is 000, a single request serves every pending source. Its data bits 15:0 equal the message data register, unchanged.
- R5: When the message-count field is 001, the post-queue request carries data bit 0 = 0. The doorbell/message request carries data bit 0 = 1. Bits 15:1 equal the register value. One request serves both doorbell and message.
- R6: Message-count values 010 through 111 behave exactly like 001.
- R7: In two-message mode, a pending post-queue source is served before the doorbell/message class.
- R8: While req_valid_o is high, req_be_o is 4'hF, req_data_o[31:16] is 0, and req_addr_o equals the address register.
- R9: While enable is 0, no request is raised and pending sources are kept. Setting enable later issues the held requests.
- R10: While req_valid_o is high and req_ready_i is low, data, address and byte enables stay stable. Register writes in that window do not change them.
- R11: A request is accepted when valid and ready are both high. Valid drops at that edge, and the pending bits the request served are cleared. A source edge from idle raises valid on the second clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_idx_i | input | 2 | Register index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational on index) |
| irq_post_i | input | 1 | Post-queue interrupt source |
| irq_door_i | input | 1 | Doorbell interrupt source |
| irq_msg_i | input | 1 | Message interrupt source |
| req_valid_o | output | 1 | Write request valid |
| req_ready_i | input | 1 | Write request accepted by bus master |
| req_addr_o | output | 32 | Write target address |
| req_data_o | output | 32 | Write data word |
| req_be_o | output | 4 | Write byte enables |

## Verification
A source edge presented before clock edge k sets its pending bit at edge k. The request is launched at edge k+1, so valid is first seen after the second edge. After an accept at edge n, valid is low following that edge, and any remaining class launches at edge n+1. The bench drives inputs and samples outputs on falling edges. It checks valid exactly at the one- and two-edge points, and it waits a bounded number of cycles only where several requests follow in sequence. For every message-count value and every source mix, it computes the expected sequence of data words in arithmetic.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned MD_W   = 16;
  localparam int unsigned MME_W  = 3;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned BE_W   = BUS_W / 8;

  typedef enum logic [1:0] {
    SRC_POST = 2'd0,
    SRC_DOOR = 2'd1,
    SRC_MSG  = 2'd2
  } msi_src_e;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 2'd0,
    IDX_ADDR = 2'd1,
    IDX_DATA = 2'd2,
    IDX_RSVD = 2'd3
  } msi_idx_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_MME_LSB = 4;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned MW = MD_W,
  parameter int unsigned CW = MME_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             en_o,
  output logic [CW-1:0]    mme_o,
  output logic [DW-1:0]    addr_o,
  output logic [MW-1:0]    md_o
);
  localparam int unsigned AW_HI = DW - 2;

  logic             en_q;
  logic [CW-1:0]    mme_q;
  logic [AW_HI-1:0] addr_q;
  logic [MW-1:0]    md_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mme_q  <= '0;
      addr_q <= '0;
      md_q   <= '0;
    end else if (we_i) begin
      unique case (msi_idx_e'(idx_i))
        IDX_CTRL: begin
          en_q  <= wdata_i[CTRL_EN_BIT];
          mme_q <= wdata_i[CTRL_MME_LSB +: CW];
        end
        IDX_ADDR: addr_q <= wdata_i[DW-1:2];
        IDX_DATA: md_q   <= wdata_i[MW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (msi_idx_e'(idx_i))
      IDX_CTRL: begin
        rdata_o[CTRL_EN_BIT]         = en_q;
        rdata_o[CTRL_MME_LSB +: CW]  = mme_q;
      end
      IDX_ADDR: rdata_o = {addr_q, 2'b00};
      IDX_DATA: rdata_o[MW-1:0] = md_q;
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mme_o  = mme_q;
  assign addr_o = {addr_q, 2'b00};
  assign md_o   = md_q;
endmodule

// File: rtl/msi_edge_pend.sv
module msi_edge_pend #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic prev_q, pend_q, rise;
    assign rise = irq_i[g] & ~prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= irq_i[g];
        // a fresh edge wins over a same-cycle clear
        pend_q <= (pend_q & ~clr_i[g]) | rise;
      end
    end
    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/msi_req_engine.sv
module msi_req_engine
  import msi_pkg::*;
#(
  parameter int unsigned DW = BUS_W,
  parameter int unsigned MW = MD_W,
  parameter int unsigned N  = NSRC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  input  logic          en_i,
  input  logic          two_msg_i,
  input  logic [DW-1:0] addr_i,
  input  logic [MW-1:0] md_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [DW/8-1:0] be_o,
  output logic [N-1:0]  clr_o
);
  localparam int unsigned BW = DW / 8;

  logic          valid_q;
  logic [DW-1:0] addr_q, data_q;
  logic [BW-1:0] be_q;
  logic [N-1:0]  served_q;

  logic          launch;
  logic [N-1:0]  serve_mask;
  logic [MW-1:0] md_sel;

  always_comb begin
    serve_mask = pend_i;
    md_sel     = md_i;
    if (two_msg_i) begin
      if (pend_i[SRC_POST]) begin
        serve_mask = '0;
        serve_mask[SRC_POST] = 1'b1;
        md_sel[0] = 1'b0;
      end else begin
        serve_mask[SRC_POST] = 1'b0;
        md_sel[0] = 1'b1;
      end
    end
  end

  assign launch = ~valid_q & en_i & (|pend_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      be_q     <= '0;
      served_q <= '0;
    end else if (launch) begin
      valid_q  <= 1'b1;
      addr_q   <= addr_i;
      data_q   <= {{(DW-MW){1'b0}}, md_sel};
      be_q     <= '1;
      served_q <= serve_mask;
    end else if (valid_q && ready_i) begin
      valid_q  <= 1'b0;
      be_q     <= '0;
      served_q <= '0;
    end
  end

  assign clr_o   = (valid_q && ready_i) ? served_q : '0;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
  assign be_o    = be_q;
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [BUS_W-1:0] cfg_wdata_i,
  output logic [BUS_W-1:0] cfg_rdata_o,
  input  logic             irq_post_i,
  input  logic             irq_door_i,
  input  logic             irq_msg_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [BUS_W-1:0] req_addr_o,
  output logic [BUS_W-1:0] req_data_o,
  output logic [BE_W-1:0]  req_be_o
);
  logic             msi_en;
  logic [MME_W-1:0] mme;
  logic             two_msg;
  logic [BUS_W-1:0] addr_reg;
  logic [MD_W-1:0]  md_reg;
  logic [NSRC-1:0]  irq_vec, pend, clr;

  assign irq_vec = {irq_msg_i, irq_door_i, irq_post_i};
  // any non-zero count field selects two-message operation
  assign two_msg = |mme;

  msi_cfg_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .en_o    (msi_en),
    .mme_o   (mme),
    .addr_o  (addr_reg),
    .md_o    (md_reg)
  );

  msi_edge_pend #(.N(NSRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_vec),
    .clr_i  (clr),
    .pend_o (pend)
  );

  msi_req_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .en_i      (msi_en),
    .two_msg_i (two_msg),
    .addr_i    (addr_reg),
    .md_i      (md_reg),
    .ready_i   (req_ready_i),
    .valid_o   (req_valid_o),
    .addr_o    (req_addr_o),
    .data_o    (req_data_o),
    .be_o      (req_be_o),
    .clr_o     (clr)
  );
endmodule

// File: rtl/msi_msg_gen_chk.sv
module msi_msg_gen_chk
  import msi_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [BUS_W-1:0] req_addr_o,
  input logic [BUS_W-1:0] req_data_o,
  input logic [BE_W-1:0]  req_be_o,
  input logic             msi_en,
  input logic             two_msg,
  input logic [NSRC-1:0]  pend,
  input logic [MD_W-1:0]  md_reg
);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_data_o)
      && $stable(req_addr_o) && $stable(req_be_o));

  a_r8_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_be_o == '1 && req_data_o[BUS_W-1:MD_W] == '0);

  a_r11_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);

  a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(msi_en) && $past(pend) != '0);

  a_r4_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) && !$past(two_msg) |-> req_data_o[MD_W-1:0] == $past(md_reg));

  a_r7_post_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) && $past(two_msg) |-> req_data_o[0] == !$past(pend[SRC_POST]));
endmodule

bind msi_msg_gen msi_msg_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .req_data_o  (req_data_o),
  .req_be_o    (req_be_o),
  .msi_en      (msi_en),
  .two_msg     (two_msg),
  .pend        (pend),
  .md_reg      (md_reg)
);

// File: tb/tb_msi_msg_gen.sv
module tb_msi_msg_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ADDR = 32'h8000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        irq_post_i = 1'b0, irq_door_i = 1'b0, irq_msg_i = 1'b0;
  logic        req_valid_o;
  logic        req_ready_i = 1'b0;
  logic [31:0] req_addr_o, req_data_o;
  logic [3:0]  req_be_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  msi_msg_gen dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] d);
    cfg_idx_i = idx; cfg_wdata_i = d; cfg_we_i = 1'b1;
    step();
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] idx, logic [31:0] exp);
    cfg_idx_i = idx;
    #1;
    chk(req, cfg_rdata_o, exp);
  endtask

  task automatic pulse(logic [2:0] m);
    {irq_msg_i, irq_door_i, irq_post_i} = m;
    step();
    {irq_msg_i, irq_door_i, irq_post_i} = 3'b000;
  endtask

  // wait for a request, check its contents, accept it
  task automatic take(string req, logic [31:0] exp_data);
    int w = 0;
    while (!req_valid_o && w < 6) begin step(); w++; end
    chk(req, {31'b0, req_valid_o}, 32'd1);
    chk(req, req_data_o, exp_data);
    chk("R8", req_addr_o, ADDR);
    chk("R8", {28'b0, req_be_o}, 32'hF);
    req_ready_i = 1'b1;
    step();
    req_ready_i = 1'b0;
  endtask

  task automatic quiet(string req, int n);
    for (int i = 0; i < n; i++) begin
      chk(req, {31'b0, req_valid_o}, 32'd0);
      step();
    end
  endtask

  initial begin
    step(2);
    chk("R1", {31'b0, req_valid_o}, 32'd0);
    rd_chk("R1", 2'd0, 32'h0);
    rd_chk("R1", 2'd1, 32'h0);
    rd_chk("R1", 2'd2, 32'h0);
    rst_ni = 1'b1;
    step();

    // R2 register access
    wr(2'd2, 32'hABCD_1234); rd_chk("R2", 2'd2, 32'h0000_1234);
    wr(2'd1, 32'hFFFF_FFFF); rd_chk("R2", 2'd1, 32'hFFFF_FFFC);
    wr(2'd0, 32'hFFFF_FFFF); rd_chk("R2", 2'd0, 32'h0000_0071);
    wr(2'd3, 32'h1234_5678); rd_chk("R2", 2'd3, 32'h0);
    wr(2'd1, ADDR);

    // R11 latency from idle, single-message mode
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h0000_BEEF);
    irq_post_i = 1'b1;
    step();
    chk("R11", {31'b0, req_valid_o}, 32'd0);
    step();
    chk("R11", {31'b0, req_valid_o}, 32'd1);
    irq_post_i = 1'b0;
    // R10 hold while not ready, register changes ignored
    wr(2'd2, 32'h0000_1111);
    step(3);
    chk("R10", req_data_o, 32'h0000_BEEF);
    chk("R10", {31'b0, req_valid_o}, 32'd1);
    take("R11", 32'h0000_BEEF);
    quiet("R11", 4);

    // sweep: every count-field value, every source mix
    for (int mme = 0; mme < 8; mme++) begin
      for (int m = 1; m < 8; m++) begin
        logic [15:0] d;
        logic [2:0]  mk;
        string rq;
        mk = 3'(m);
        d = 16'h5A00 | (16'(mme) << 4) | (16'(mk) << 1) | 16'(mk[0]);
        rq = (mme == 0) ? "R4" : (mme == 1) ? "R5" : "R6";
        wr(2'd0, 32'h1 | (32'(mme) << 4));
        wr(2'd2, {16'h0, d});
        pulse(mk);
        if (mme == 0) begin
          take(rq, {16'h0, d});
        end else begin
          if (mk[0]) take((mk[2:1] != 0) ? "R7" : rq, {16'h0, d & 16'hFFFE});
          if (mk[2:1] != 0) take(rq, {16'h0, d | 16'h0001});
        end
        quiet(rq, 3);
      end
    end

    // R3 held-high source gives one request
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h0000_0C0C);
    irq_door_i = 1'b1;
    step();
    take("R3", 32'h0000_0C0C);
    quiet("R3", 6);
    irq_door_i = 1'b0;
    step();
    pulse(3'b010);
    take("R3", 32'h0000_0C0C);

    // R9 disabled: kept pending, issued on enable
    wr(2'd0, 32'h10);
    pulse(3'b101);
    quiet("R9", 6);
    wr(2'd0, 32'h11);
    take("R9", 32'h0000_0C0C);
    take("R9", 32'h0000_0C0D);
    quiet("R9", 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule